// File: doc/BRIEF.md
# Dual-Register Output Compare Channel

This block is one output compare channel. It watches the count of one of two free-running 16-bit timers and drives a single output pin according to a 3-bit mode held in its control register. Two 16-bit compare registers have fixed roles. The primary register marks the first edge. The secondary register marks the second edge, or it buffers the duty value in the PWM modes.

The single-match modes set, clear or toggle the pin when the count equals the primary value. The dual-match modes produce one pulse, or a train of pulses, running from the primary match to the secondary match. In the PWM modes the pin rises on the selected timer's period strobe and falls when the count reaches the duty value. The duty value is taken from the secondary register only at a period strobe. In one PWM mode an active-low fault input forces the pin low and latches that state until software rewrites the control register.

An interrupt flag records every compare, PWM and fault event. It stays set until software writes a 0 to clear it. Software reaches the registers through a simple synchronous write port.

Top module: `ocmp_channel`

## Requirements
- R1: After reset, the pin, the output enable and the interrupt flag are all 0, and the control, primary and secondary registers hold 0.
- R2: When tb_sel is 0, the comparator uses cnt_a and per_a. When tb_sel is 1, it uses cnt_b and per_b. The other timer has no effect.
- R3: pin_oe is 1 exactly when the mode field (control bits 2:0) is nonzero. In mode 000 the pin is driven low.
- R4: Mode 001 drives the pin high, mode 010 drives it low, and mode 011 inverts it, each in the clock after a cycle in which the selected count equals the primary register. Each such match sets the flag.
- R5: Mode 100 takes the pin high after a primary match. It takes the pin low after the first secondary match that occurs while the pin is high, or in the same cycle as the primary match, and that match sets the flag. The channel then stays low until the control register is written. Mode 101 behaves the same way but re-arms after every pulse.
- R6: In modes 110 and 111, a period strobe copies the secondary register into the active duty value, sets the flag, and takes the pin high in the next clock. The pin goes low in the clock after a cycle in which the count equals the active duty value.
- R7: A copied duty value of 0 keeps the pin low for the whole period. A duty value the count never reaches keeps the pin high for the whole period.
- R8: A write to the secondary register in a PWM mode changes nothing until the next period strobe.
- R9: In mode 111, fault_n low forces the pin low in the next clock, sets the flag once, and holds the pin low until the control register is written. Mode 110 ignores fault_n.
- R10: Only a write of 0 to bit 0 at address 3 clears the flag. A write of 1 there has no effect. A flag-setting event in the same cycle wins over the clear.
- R11: The write port uses these addresses: 0 for control (mode in bits 2:0), 1 for primary, 2 for secondary, 3 for flag clear. A written value is in use from the next clock. A control write also drives the pin low, re-arms mode 100, clears the fault latch, and produces no event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_sel | input | 1 | Timebase select: 0 uses timer A, 1 uses timer B |
| cnt_a | input | 16 | Timer A count |
| per_a | input | 1 | Timer A period-match strobe |
| cnt_b | input | 16 | Timer B count |
| per_b | input | 1 | Timer B period-match strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| fault_n | input | 1 | Active-low fault input, used in mode 111 |
| pin_out | output | 1 | Compare output pin |
| pin_oe | output | 1 | Output enable |
| irq_flag | output | 1 | Interrupt flag |

## Verification
The assertions check several rules on every cycle:
- the pin is low in the disabled mode, under a fault, after a zero-duty period strobe, and once a single pulse has finished;
- a single-mode match always sets the flag;
- a fault always sets the flag;
- a primary write always lands in its register.

Only the bench scenarios can show the rest: the shape of a whole pulse or PWM period, the timebase selection, the deferred duty update, and the clearing and write-1 behaviour of the flag. The bench shows these by comparing the pin and flag every cycle against a model built from the requirements, and by counting high cycles over full periods.

// File: rtl/ocmp_pkg.sv
`timescale 1ns/1ps
package ocmp_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        OC_OFF    = 3'd0,
        OC_SET    = 3'd1,
        OC_CLR    = 3'd2,
        OC_TGL    = 3'd3,
        OC_PULSE1 = 3'd4,
        OC_PULSEN = 3'd5,
        OC_PWM    = 3'd6,
        OC_PWMF   = 3'd7
    } oc_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_PRI  = 2'd1,
        RA_SEC  = 2'd2,
        RA_FLAG = 2'd3
    } oc_addr_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } oc_wr_t;

    typedef struct packed {
        logic             out;
        logic             fault;
        logic             armed;
        logic [CNT_W-1:0] duty;
    } oc_state_t;

    function automatic logic is_pwm(oc_mode_e m);
        return (m == OC_PWM) || (m == OC_PWMF);
    endfunction

    function automatic logic is_single(oc_mode_e m);
        return (m == OC_SET) || (m == OC_CLR) || (m == OC_TGL);
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
`timescale 1ns/1ps
module ocmp_regs
    import ocmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  oc_wr_t           wr,
    output oc_mode_e         mode_o,
    output logic [CNT_W-1:0] pri_o,
    output logic [CNT_W-1:0] sec_o,
    output logic             ctrl_wr_o,
    output logic             flag_clr_o
);
    oc_mode_e         mode_q;
    logic [CNT_W-1:0] pri_q;
    logic [CNT_W-1:0] sec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OC_OFF;
            pri_q  <= '0;
            sec_q  <= '0;
        end else if (wr.en) begin
            case (oc_addr_e'(wr.addr))
                RA_CTRL: mode_q <= oc_mode_e'(wr.data[MODE_W-1:0]);
                RA_PRI:  pri_q  <= wr.data[CNT_W-1:0];
                RA_SEC:  sec_q  <= wr.data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign ctrl_wr_o  = wr.en && (oc_addr_e'(wr.addr) == RA_CTRL);
    assign flag_clr_o = wr.en && (oc_addr_e'(wr.addr) == RA_FLAG) && !wr.data[0];
    assign mode_o     = mode_q;
    assign pri_o      = pri_q;
    assign sec_o      = sec_q;

    // R11: a primary write is visible on the next clock
    a_r11_pri_load: assert property (@(posedge clk) disable iff (rst)
        (wr.en && oc_addr_e'(wr.addr) == RA_PRI) |=> (pri_q == $past(wr.data[CNT_W-1:0])));

endmodule

// File: rtl/ocmp_tbmux.sv
`timescale 1ns/1ps
module ocmp_tbmux
    import ocmp_pkg::*;
#(
    parameter int NUM_TB = 2
) (
    input  logic                        sel,
    input  logic [NUM_TB-1:0][CNT_W-1:0] cnt_i,
    input  logic [NUM_TB-1:0]            per_i,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        per_o
);
    localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1;

    logic [SEL_W-1:0] idx;
    assign idx = SEL_W'(sel);

    always_comb begin
        cnt_o = cnt_i[0];
        per_o = per_i[0];
        for (int k = 1; k < NUM_TB; k++) begin
            if (idx == SEL_W'(k)) begin
                cnt_o = cnt_i[k];
                per_o = per_i[k];
            end
        end
    end
endmodule

// File: rtl/ocmp_core.sv
`timescale 1ns/1ps
module ocmp_core
    import ocmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  oc_mode_e         mode_i,
    input  logic [CNT_W-1:0] pri_i,
    input  logic [CNT_W-1:0] sec_i,
    input  logic             ctrl_wr_i,
    input  logic             flag_clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             per_i,
    input  logic             fault_n_i,
    output logic             out_o,
    output logic             flag_o
);
    oc_state_t st_q, st_d;
    logic      flag_q;
    logic      event_d;
    logic      hit_pri, hit_sec, hit_duty;

    assign hit_pri  = (cnt_i == pri_i);
    assign hit_sec  = (cnt_i == sec_i);
    assign hit_duty = (cnt_i == st_q.duty);

    always_comb begin
        st_d    = st_q;
        event_d = 1'b0;
        if (ctrl_wr_i) begin
            st_d.out   = 1'b0;
            st_d.fault = 1'b0;
            st_d.armed = 1'b1;
        end else begin
            case (mode_i)
                OC_OFF: st_d.out = 1'b0;
                OC_SET: if (hit_pri) begin st_d.out = 1'b1;       event_d = 1'b1; end
                OC_CLR: if (hit_pri) begin st_d.out = 1'b0;       event_d = 1'b1; end
                OC_TGL: if (hit_pri) begin st_d.out = ~st_q.out;  event_d = 1'b1; end
                OC_PULSE1, OC_PULSEN: begin
                    if (st_q.armed) begin
                        if (hit_sec && (st_q.out || hit_pri)) begin
                            st_d.out = 1'b0;
                            event_d  = 1'b1;
                            if (mode_i == OC_PULSE1) st_d.armed = 1'b0;
                        end else if (hit_pri) begin
                            st_d.out = 1'b1;
                        end
                    end
                end
                default: begin
                    if (mode_i == OC_PWMF && (st_q.fault || !fault_n_i)) begin
                        st_d.out = 1'b0;
                        if (!st_q.fault) begin
                            st_d.fault = 1'b1;
                            event_d    = 1'b1;
                        end
                    end else if (per_i) begin
                        st_d.duty = sec_i;
                        st_d.out  = (sec_i != '0);
                        event_d   = 1'b1;
                    end else if (hit_duty) begin
                        st_d.out = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{out: 1'b0, fault: 1'b0, armed: 1'b1, duty: '0};
            flag_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (event_d)         flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign out_o  = st_q.out;
    assign flag_o = flag_q;

    // R3: disabled mode leaves the pin low
    a_r3_off_low: assert property (@(posedge clk) disable iff (rst)
        (mode_i == OC_OFF) |=> !st_q.out);
    // R4: a single-mode match raises the flag
    a_r4_match_flag: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr_i && is_single(mode_i) && hit_pri) |=> flag_q);
    // R5: a finished single pulse keeps the pin low
    a_r5_single_done: assert property (@(posedge clk) disable iff (rst)
        (mode_i == OC_PULSE1 && !st_q.armed) |-> !st_q.out);
    // R7: a zero duty copied at a period strobe keeps the pin low
    a_r7_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr_i && mode_i == OC_PWM && per_i && sec_i == '0) |=> !st_q.out);
    // R9: an active fault forces the pin low
    a_r9_fault_low: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr_i && mode_i == OC_PWMF && !fault_n_i) |=> !st_q.out);
    // R9: entering the fault state raises the flag
    a_r9_fault_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.fault) |-> flag_q);

endmodule

// File: rtl/ocmp_channel.sv
`timescale 1ns/1ps
module ocmp_channel
    import ocmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_sel,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic              per_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic              per_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fault_n,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq_flag
);
    oc_wr_t           wr;
    oc_mode_e         mode;
    logic [CNT_W-1:0] pri, sec, cnt_sel;
    logic             ctrl_wr, flag_clr, per_sel;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    ocmp_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .mode_o     (mode),
        .pri_o      (pri),
        .sec_o      (sec),
        .ctrl_wr_o  (ctrl_wr),
        .flag_clr_o (flag_clr)
    );

    ocmp_tbmux #(.NUM_TB(2)) u_mux (
        .sel   (tb_sel),
        .cnt_i ({cnt_b, cnt_a}),
        .per_i ({per_b, per_a}),
        .cnt_o (cnt_sel),
        .per_o (per_sel)
    );

    ocmp_core u_core (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .pri_i      (pri),
        .sec_i      (sec),
        .ctrl_wr_i  (ctrl_wr),
        .flag_clr_i (flag_clr),
        .cnt_i      (cnt_sel),
        .per_i      (per_sel),
        .fault_n_i  (fault_n),
        .out_o      (pin_out),
        .flag_o     (irq_flag)
    );

    assign pin_oe = (mode != OC_OFF);

endmodule

// File: tb/tb_ocmp_channel.sv
`timescale 1ns/1ps
module tb_ocmp_channel;
    localparam int PA = 20;
    localparam int PB = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic [15:0] ca = '0, cb = '0;
    logic        w_en = 1'b0;
    logic [1:0]  w_addr = '0;
    logic [15:0] w_data = '0;
    logic        fault_n = 1'b1;
    logic        pin_out, pin_oe, irq_flag;
    logic        per_a, per_b;

    assign per_a = (ca == 16'(PA));
    assign per_b = (cb == 16'(PB));

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state, derived from the requirements
    logic [2:0]  m_mode = 3'd0;
    logic [15:0] m_pri = '0, m_sec = '0, m_duty = '0;
    logic        m_out = 0, m_flag = 0, m_fault = 0, m_armed = 1;

    always #5 clk = ~clk;

    ocmp_channel dut (
        .clk(clk), .rst(rst), .tb_sel(sel),
        .cnt_a(ca), .per_a(per_a), .cnt_b(cb), .per_b(per_b),
        .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
        .fault_n(fault_n),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1, 3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_update();
        logic [15:0] c;
        logic ph, ev, hp, hs;
        c  = sel ? cb : ca;
        ph = sel ? per_b : per_a;
        hp = (c == m_pri);
        hs = (c == m_sec);
        ev = 0;
        if (w_en && w_addr == 2'd0) begin
            m_out = 0; m_fault = 0; m_armed = 1;       // R11
        end else if (m_mode == 3'd0) begin
            m_out = 0;
        end else if (m_mode <= 3'd3) begin
            if (hp) begin
                ev = 1;
                m_out = (m_mode == 3'd1) ? 1'b1 : (m_mode == 3'd2) ? 1'b0 : ~m_out;
            end
        end else if (m_mode <= 3'd5) begin
            if (m_armed) begin
                if (hs && (m_out || hp)) begin
                    m_out = 0; ev = 1;
                    if (m_mode == 3'd4) m_armed = 0;
                end else if (hp) m_out = 1;
            end
        end else begin
            if (m_mode == 3'd7 && (m_fault || !fault_n)) begin
                m_out = 0;
                if (!m_fault) begin m_fault = 1; ev = 1; end
            end else if (ph) begin
                m_duty = m_sec; m_out = (m_sec != 0); ev = 1;
            end else if (c == m_duty) m_out = 0;
        end
        if (ev) m_flag = 1;
        else if (w_en && w_addr == 2'd3 && !w_data[0]) m_flag = 0;   // R10
        if (w_en) begin
            case (w_addr)
                2'd0: m_mode = w_data[2:0];
                2'd1: m_pri  = w_data;
                2'd2: m_sec  = w_data;
                default: ;
            endcase
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        chk(pin_out === m_out, mode_tag(m_mode), "pin_out", int'(pin_out), int'(m_out));
        chk(irq_flag === m_flag, "R10", "irq_flag", int'(irq_flag), int'(m_flag));
        chk(pin_oe === (m_mode != 0), "R3", "pin_oe", int'(pin_oe), int'(m_mode != 0));
        ca = (ca == 16'(PA)) ? '0 : ca + 1'b1;
        cb = (cb == 16'(PB)) ? '0 : cb + 1'b1;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        w_en = 1; w_addr = a; w_data = d;
        step();
        w_en = 0;
    endtask

    task automatic count_high(int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (pin_out) highs++;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int h;
        void'($urandom(32'h0C5EED01));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk(pin_out === 0, "R1", "pin_out", int'(pin_out), 0);
        chk(pin_oe === 0, "R1", "pin_oe", int'(pin_oe), 0);
        chk(irq_flag === 0, "R1", "irq_flag", int'(irq_flag), 0);

        // R4 set on match, R3 enable
        wr(2'd1, 16'd7);
        wr(2'd0, 16'd1);
        chk(pin_oe === 1, "R3", "pin_oe after enable", int'(pin_oe), 1);
        run(25);
        chk(pin_out === 1, "R4", "pin after set match", int'(pin_out), 1);

        // R2: timer B never reaches 16, timer A does
        sel = 1;
        wr(2'd1, 16'd16);
        wr(2'd0, 16'd3);
        count_high(40, h);
        chk(h == 0, "R2", "highs with timer B selected", h, 0);
        sel = 0;
        run(45);

        // R5 single pulse: high for counts 4..9, exactly once
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd9);
        wr(2'd0, 16'd4);
        count_high(60, h);
        chk(h == 6, "R5", "single pulse width", h, 6);
        wr(2'd0, 16'd5);
        run(70);

        // R6 PWM: duty 5 gives 6 high cycles per 21-cycle period
        wr(2'd2, 16'd5);
        wr(2'd0, 16'd6);
        run(25);
        count_high(PA + 1, h);
        chk(h == 6, "R6", "PWM high cycles", h, 6);

        // R7 zero duty and unreachable duty
        wr(2'd2, 16'd0);
        run(PA + 2);
        count_high(PA + 1, h);
        chk(h == 0, "R7", "zero duty highs", h, 0);
        wr(2'd2, 16'd30);
        run(PA + 2);
        count_high(PA + 1, h);
        chk(h == PA + 1, "R7", "full duty highs", h, PA + 1);

        // R8 deferred duty update
        wr(2'd2, 16'd5);
        run(PA + 2);
        while (ca != 0) step();
        wr(2'd2, 16'd15);
        while (ca != 16'd8) step();
        chk(pin_out === 0, "R8", "old duty still active", int'(pin_out), 0);
        while (ca != 0) step();
        while (ca != 16'd10) step();
        chk(pin_out === 1, "R8", "new duty after strobe", int'(pin_out), 1);

        // R9 fault latch in mode 111
        wr(2'd2, 16'd10);
        wr(2'd0, 16'd7);
        run(25);
        wr(2'd3, 16'd0);
        fault_n = 0;
        step();
        fault_n = 1;
        chk(pin_out === 0, "R9", "pin under fault", int'(pin_out), 0);
        chk(irq_flag === 1, "R9", "flag on fault", int'(irq_flag), 1);
        count_high(30, h);
        chk(h == 0, "R9", "pin held low after fault", h, 0);
        wr(2'd0, 16'd7);
        run(25);
        wr(2'd0, 16'd6);
        fault_n = 0;
        count_high(30, h);
        fault_n = 1;
        chk(h > 0, "R9", "mode 110 ignores fault", h, 1);

        // R10 flag clear behaviour
        wr(2'd0, 16'd0);
        chk(irq_flag === 1, "R10", "flag kept over control write", int'(irq_flag), 1);
        wr(2'd3, 16'd1);
        chk(irq_flag === 1, "R10", "write 1 keeps flag", int'(irq_flag), 1);
        wr(2'd3, 16'd0);
        chk(irq_flag === 0, "R10", "write 0 clears flag", int'(irq_flag), 0);
        run(30);
        chk(irq_flag === 0, "R10", "flag stays clear when off", int'(irq_flag), 0);

        // R11 control write drops the pin
        wr(2'd1, 16'd2);
        wr(2'd0, 16'd1);
        run(25);
        chk(pin_out === 1, "R4", "pin high before rewrite", int'(pin_out), 1);
        wr(2'd0, 16'd1);
        chk(pin_out === 0, "R11", "pin low after control write", int'(pin_out), 0);

        // random phase, every cycle compared against the model
        for (int blk = 0; blk < 60; blk++) begin
            sel = 1'($urandom_range(0, 1));
            wr(2'd1, 16'($urandom_range(0, 24)));
            wr(2'd2, 16'($urandom_range(0, 24)));
            wr(2'd0, 16'($urandom_range(0, 7)));
            for (int i = 0; i < 50; i++) begin
                fault_n = ($urandom_range(0, 39) != 0);
                if ($urandom_range(0, 29) == 0) wr(2'd3, 16'($urandom_range(0, 1)));
                else if ($urandom_range(0, 39) == 0) wr(2'd2, 16'($urandom_range(0, 24)));
                else step();
            end
            fault_n = 1;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule